// File: doc/BRIEF.md
# DDR Command Decoder and Bank State Tracker

This block watches the command pins of a DDR memory bus from the memory side. On every rising clock edge it samples chip select, the row strobe, the column strobe, write enable, the bank-select field and the address bus. It decodes activate, single-bank precharge, all-bank precharge, write, read, refresh, mode-register load and no-operation. For each bank it keeps an idle or active state and the row that was opened.

The tracker flags protocol misuse. An access to an idle bank, an activate to a bank that is already open, or a refresh while any bank is open produces a one-cycle error pulse. Each bank also counts how long it has been open and raises a per-bank flag once that time passes a parameterised maximum. A read or write with the auto-precharge bit set closes its bank a fixed number of cycles after the command. The block is meant to sit beside a controller or a memory model as a protocol monitor.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset every bank is idle, every row output is zero, and `cmd_o`, `illegal_access_o` and `tras_err_o` are zero.
- R2: With chip select low, pattern RAS#=0 CAS#=1 WE#=1 is an activate: an idle bank named by `ba_i` becomes active at that edge and its row output takes `addr_i`.
- R3: Pattern RAS#=0 CAS#=1 WE#=0 with address bit 10 low closes only the bank named by `ba_i`. All other banks keep their state.
- R4: The same pattern with address bit 10 high closes all banks, whatever the value of `ba_i`.
- R5: Pattern RAS#=1 CAS#=0 is a write when WE#=0 and a read when WE#=1. Either one to an idle bank raises `illegal_access_o` for exactly the following cycle and changes no bank state. Either one to an active bank raises no error.
- R6: An activate to a bank that is already active raises `illegal_access_o` and leaves that bank's row unchanged.
- R7: Chip select high, the pattern RAS#=1 CAS#=1 WE#=0, all three strobes high, and the mode-register pattern (all three strobes low) change no bank state and raise no error.
- R8: Each active bank counts the clock edges since it was opened. Its `tras_err_o` bit is high from the (TRAS_MAX+1)-th edge after the activate until the bank is closed.
- R9: A read or write to an active bank with address bit 10 high closes that bank exactly AP_DELAY edges after the command edge.
- R10: `cmd_o` gives the code of the command sampled at the previous edge: 0 no-op or deselect, 1 activate, 2 single-bank precharge, 3 all-bank precharge, 4 write, 5 read, 6 refresh, 7 mode-register load.
- R11: A refresh (RAS#=0 CAS#=0 WE#=1) while any bank is active raises `illegal_access_o`. A refresh with all banks idle does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address bus; bit 10 selects all-bank or auto precharge |
| cmd_o | output | 3 | Decoded command code of the previous edge |
| bank_active_o | output | 4 | Per-bank active flag |
| row_o | output | 52 | Latched row per bank, bank b at bits [13b+12:13b] |
| illegal_access_o | output | 1 | One-cycle protocol error pulse |
| tras_err_o | output | 4 | Per-bank flag for open time over the limit |

## Verification
The bench closes each bank in turn with address bit 10 low. A decoder that ignored that bit, or took the bank field wrongly, would close the wrong banks or every bank. It counts edges after an activate up to one past the limit. A comparison off by one would raise the open-time flag one edge early or late. It also times auto-precharge to the exact edge, re-activates open banks to confirm the row is not overwritten, and fires a deselect carrying an activate pattern, which a design that ignored chip select would obey.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_PREA = 3'd3,
    CMD_WR   = 3'd4,
    CMD_RD   = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic a10_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_n_i) begin
      case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b100:  cmd_o = CMD_WR;
        3'b101:  cmd_o = CMD_RD;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;  // 111 no-op, 110 no state change
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W    = 13,
  parameter int TRAS_MAX = 12,
  parameter int AP_DELAY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             pre_i,
  input  logic             ap_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o,
  output logic             tras_err_o
);
  localparam int CNT_W = $clog2(TRAS_MAX + 2);
  localparam int AP_W  = $clog2(AP_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TRAS_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(TRAS_MAX);

  logic             active_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ap_pend_q;
  logic [AP_W-1:0]  ap_cnt_q;
  logic             ap_fire;

  assign ap_fire = ap_pend_q && (ap_cnt_q == AP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      row_q     <= '0;
      cnt_q     <= '0;
      ap_pend_q <= 1'b0;
      ap_cnt_q  <= '0;
    end else if (pre_i || ap_fire) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      ap_pend_q <= 1'b0;
      ap_cnt_q  <= '0;
    end else if (act_i && !active_q) begin
      active_q <= 1'b1;
      row_q    <= row_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (ap_pend_q) begin
        ap_cnt_q <= ap_cnt_q - 1'b1;
      end else if (ap_i) begin
        ap_pend_q <= 1'b1;
        ap_cnt_q  <= AP_W'(AP_DELAY);
      end
    end
  end

  assign active_o   = active_q;
  assign row_o      = row_q;
  assign tras_err_o = active_q && (cnt_q > CNT_LIM);

  p_act_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !active_q && !pre_i) |=> (active_q && row_q == $past(row_i)));

  p_row_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> $stable(row_q));

  p_tras_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tras_err_o && !pre_i && !ap_pend_q) |=> tras_err_o);
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int ROW_W    = 13,
  parameter int AP_BIT   = 10,
  parameter int TRAS_MAX = 12,
  parameter int AP_DELAY = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_n_i,
  input  logic                     ras_n_i,
  input  logic                     cas_n_i,
  input  logic                     we_n_i,
  input  logic [$clog2(BANKS)-1:0] ba_i,
  input  logic [ROW_W-1:0]         addr_i,
  output logic [2:0]               cmd_o,
  output logic [BANKS-1:0]         bank_active_o,
  output logic [BANKS*ROW_W-1:0]   row_o,
  output logic                     illegal_access_o,
  output logic [BANKS-1:0]         tras_err_o
);
  localparam int BA_W = $clog2(BANKS);

  cmd_e             cmd_now;
  logic             is_rw;
  logic             hit_active;
  logic             illegal_now;
  logic [BANKS-1:0] act_en, pre_en, ap_en;
  cmd_e             cmd_q;
  logic             illegal_q;

  ddr_cmd_decode u_decode (
    .cs_n_i  (cs_n_i),
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .a10_i   (addr_i[AP_BIT]),
    .cmd_o   (cmd_now)
  );

  assign is_rw      = (cmd_now == CMD_WR) || (cmd_now == CMD_RD);
  assign hit_active = bank_active_o[ba_i];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic sel;
    assign sel       = (ba_i == BA_W'(b));
    assign act_en[b] = (cmd_now == CMD_ACT) && sel;
    assign pre_en[b] = (cmd_now == CMD_PREA) || ((cmd_now == CMD_PRE) && sel);
    assign ap_en[b]  = is_rw && sel && addr_i[AP_BIT];

    ddr_bank_slot #(
      .ROW_W    (ROW_W),
      .TRAS_MAX (TRAS_MAX),
      .AP_DELAY (AP_DELAY)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (act_en[b]),
      .row_i      (addr_i),
      .pre_i      (pre_en[b]),
      .ap_i       (ap_en[b]),
      .active_o   (bank_active_o[b]),
      .row_o      (row_o[b*ROW_W +: ROW_W]),
      .tras_err_o (tras_err_o[b])
    );
  end

  assign illegal_now = (is_rw && !hit_active)
                    || ((cmd_now == CMD_ACT) && hit_active)
                    || ((cmd_now == CMD_REF) && (|bank_active_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_NOP;
      illegal_q <= 1'b0;
    end else begin
      cmd_q     <= cmd_now;
      illegal_q <= illegal_now;
    end
  end

  assign cmd_o            = cmd_q;
  assign illegal_access_o = illegal_q;

  p_idle_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rw && !bank_active_o[ba_i]) |=> illegal_access_o);

  p_close_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_now == CMD_PREA) |=> (bank_active_o == '0));

  p_ref_open_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_now == CMD_REF) && (|bank_active_o)) |=> illegal_access_o);

  p_deselect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (!illegal_access_o && cmd_o == 3'd0));
endmodule

// File: tb/ddr_cmd_tracker_tb_top.sv
module ddr_cmd_tracker_tb_top;
  localparam int BANKS = 4;
  localparam int ROW_W = 13;
  localparam int TRAS_MAX = 12;
  localparam int AP_DELAY = 2;
  localparam logic [12:0] A10 = 13'h0400;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [2:0] cmd;
  logic [BANKS-1:0] bank_active, tras_err;
  logic [BANKS*ROW_W-1:0] row;
  logic illegal;

  int tests = 0;
  int fails = 0;
  logic [BANKS-1:0] exp_active = '0;
  logic [12:0] exp_row [BANKS];

  always #2 clk = ~clk;

  ddr_cmd_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
    .cmd_o(cmd), .bank_active_o(bank_active), .row_o(row),
    .illegal_access_o(illegal), .tras_err_o(tras_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic c, input logic r, input logic s, input logic w,
                       input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = s; we_n = w; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();
    issue(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 13'h0);
  endtask

  task automatic check_state(input string req);
    check({req, " active"}, 32'(bank_active), 32'(exp_active));
    for (int b = 0; b < BANKS; b++)
      if (exp_active[b]) check({req, " row"}, 32'(row[b*ROW_W +: ROW_W]), 32'(exp_row[b]));
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [12:0] r;
    for (int b = 0; b < BANKS; b++) exp_row[b] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 active", 32'(bank_active), 0);
    check("R1 row", 32'(|row), 0);
    check("R1 cmd", 32'(cmd), 0);
    check("R1 illegal", 32'(illegal), 0);
    check("R1 tras", 32'(tras_err), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 open every bank
    for (int b = 0; b < BANKS; b++) begin
      r = 13'((b * 1237 + 77) & 13'h1fff);
      issue(0, 0, 1, 1, 2'(b), r);
      exp_active[b] = 1'b1; exp_row[b] = r;
      check_state("R2");
      check("R2 illegal", 32'(illegal), 0);
      check("R10 act code", 32'(cmd), 1);
    end

    // R5 legal accesses
    for (int b = 0; b < BANKS; b++) begin
      issue(0, 1, 0, 0, 2'(b), 13'h0012);
      check("R5 legal write", 32'(illegal), 0);
      check("R10 write code", 32'(cmd), 4);
      issue(0, 1, 0, 1, 2'(b), 13'h0034);
      check("R5 legal read", 32'(illegal), 0);
      check("R10 read code", 32'(cmd), 5);
    end

    // R3 close each bank alone, then R5 idle access
    for (int pb = 0; pb < BANKS; pb++) begin
      issue(0, 0, 1, 0, 2'(pb), 13'h1bff);
      exp_active[pb] = 1'b0;
      check_state("R3");
      check("R10 pre code", 32'(cmd), 2);
      issue(0, 1, 0, 1, 2'(pb), 13'h0005);
      check("R5 idle read", 32'(illegal), 1);
      check_state("R5 idle read");
      issue(0, 1, 0, 0, 2'(pb), 13'h0006);
      check("R5 idle write", 32'(illegal), 1);
      nop();
      check("R5 pulse ends", 32'(illegal), 0);
      r = 13'((pb * 311 + 900) & 13'h1fff);
      issue(0, 0, 1, 1, 2'(pb), r);
      exp_active[pb] = 1'b1; exp_row[pb] = r;
      check_state("R2 reopen");
    end

    // R6 activate an open bank
    issue(0, 0, 1, 1, 2'd0, 13'h1555);
    check("R6 illegal", 32'(illegal), 1);
    check_state("R6");

    // R7 no state change
    issue(0, 0, 1, 0, 2'd2, 13'h0000);
    exp_active[2] = 1'b0;
    issue(1, 0, 1, 1, 2'd2, 13'h0abc);
    check_state("R7 deselect");
    check("R7 deselect code", 32'(cmd), 0);
    check("R7 deselect err", 32'(illegal), 0);
    issue(0, 0, 0, 0, 2'd2, 13'h0033);
    check_state("R7 mrs");
    check("R10 mrs code", 32'(cmd), 7);
    check("R7 mrs err", 32'(illegal), 0);
    issue(0, 1, 1, 0, 2'd2, 13'h0400);
    check_state("R7 110 pattern");
    check("R7 110 err", 32'(illegal), 0);

    // R11 refresh with open banks
    issue(0, 0, 0, 1, 2'd0, 13'h0);
    check("R11 refresh open", 32'(illegal), 1);
    check("R10 ref code", 32'(cmd), 6);
    check_state("R11");

    // R4 close all, bank field ignored
    issue(0, 0, 1, 0, 2'd2, A10);
    exp_active = '0;
    check_state("R4");
    check("R10 prea code", 32'(cmd), 3);
    issue(0, 0, 0, 1, 2'd0, 13'h0);
    check("R11 refresh idle", 32'(illegal), 0);

    // R8 open-time limit on bank 3
    issue(0, 0, 1, 1, 2'd3, 13'h0101);
    exp_active[3] = 1'b1; exp_row[3] = 13'h0101;
    for (int i = 1; i <= TRAS_MAX + 3; i++) begin
      nop();
      check("R8 tras", 32'(tras_err), (i > TRAS_MAX) ? 32'h8 : 32'h0);
    end
    issue(0, 0, 1, 0, 2'd3, 13'h0);
    exp_active[3] = 1'b0;
    check("R8 tras cleared", 32'(tras_err), 0);

    // R9 auto-precharge on write and read
    for (int k = 0; k < 2; k++) begin
      issue(0, 0, 1, 1, 2'd2, 13'h0222);
      exp_active[2] = 1'b1; exp_row[2] = 13'h0222;
      issue(0, 1, 0, (k == 1), 2'd2, A10 | 13'h0007);
      check("R9 ap cmd err", 32'(illegal), 0);
      check("R9 ap at cmd", 32'(bank_active[2]), 1);
      for (int i = 1; i <= AP_DELAY; i++) begin
        nop();
        check("R9 ap timing", 32'(bank_active[2]), (i < AP_DELAY) ? 1 : 0);
      end
      exp_active[2] = 1'b0;
      check_state("R9 others");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule